// File: doc/BRIEF.md
# Automatic RTS Flow Control

This block drives the active-low RTS# line of a serial port so that a remote transmitter is told to pause and resume according to how full the local receive FIFO is. Software first turns the automatic function on with an enhanced-feature enable bit. It then arms the function by setting either modem-control RTS bit. From that point the hardware de-asserts RTS# (drives it high, meaning "stop sending") when the FIFO fill count reaches a pause threshold. It asserts RTS# again only once the count falls below a separate, lower resume threshold.

When the automatic function is off, RTS# is the inverse of the modem-control RTS request. Each change of the RTS# pin can set a dedicated interrupt status bit, provided the RTS interrupt enable is set. That enable bit can only be written while a second enhanced-feature bit unlocks it. Reading the interrupt status register clears the status bit and drops the request. The FIFO and the chip-level interrupt priority logic sit outside this block.

Top module: `rts_flow_ctrl`

## Requirements
- R1: After reset, rts_n is 1, irq and rts_int_flag are 0, and rts_int_en is 0.
- R2: While auto_rts_en is 0, rts_n equals the inverse of (mcr_rts_a OR mcr_rts_b) one clock after those inputs are applied.
- R3: While auto_rts_en is 1 and both mcr_rts_a and mcr_rts_b are 0, rts_n is 1 whatever the FIFO level.
- R4: While auto_rts_en is 1 and a modem-control RTS bit is 1, rts_n becomes 1 one clock after rx_level is greater than or equal to pause_level.
- R5: Once paused, rts_n stays 1 while rx_level is at or above resume_level, and it returns to 0 one clock after rx_level is below resume_level (and below pause_level).
- R6: When the thresholds overlap, the pause condition (rx_level >= pause_level) takes priority over the resume condition.
- R7: A write (int_en_we = 1) updates rts_int_en from int_en_wdata only when feat_unlock is 1; a write with feat_unlock at 0 leaves rts_int_en unchanged.
- R8: When rts_int_en is 1, every change of rts_n sets rts_int_flag and irq in the same clock in which rts_n changes. When rts_int_en is 0, a change of rts_n leaves rts_int_flag at 0.
- R9: A status read (isr_rd = 1) clears rts_int_flag and irq on the next clock, unless an enabled rts_n change happens in that same clock, in which case the flag stays 1. Without a read, the flag holds.
- R10: Leaving automatic mode, or disarming it, forgets the paused state. After re-arming with rx_level between resume_level and pause_level, rts_n is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_level | input | LEVEL_W | Receive FIFO fill count |
| pause_level | input | LEVEL_W | Count at or above which the remote side is paused |
| resume_level | input | LEVEL_W | Count below which the remote side may resume |
| auto_rts_en | input | 1 | Enhanced-feature bit enabling automatic RTS |
| feat_unlock | input | 1 | Enhanced-feature bit unlocking the RTS interrupt enable |
| mcr_rts_a | input | 1 | Modem-control RTS request, first bit |
| mcr_rts_b | input | 1 | Modem-control RTS request, second bit |
| int_en_we | input | 1 | Write strobe of the interrupt-enable register |
| int_en_wdata | input | 1 | Value written to the RTS interrupt enable bit |
| isr_rd | input | 1 | Read strobe of the interrupt status register |
| rts_n | output | 1 | Active-low RTS pin |
| rts_int_en | output | 1 | Stored RTS interrupt enable bit |
| rts_int_flag | output | 1 | Interrupt status bit for an RTS transition |
| irq | output | 1 | Interrupt request for an RTS transition |

## Verification
The hardest case to reach is the hysteresis band. The line must stay de-asserted while the level sits between the two thresholds, and the result depends on whether the line arrived there from above or from below. The stimulus table walks the level up through the pause threshold, then down to exactly the resume value, then one below it. It then leaves and re-enters automatic mode inside the band, which shows that the paused memory was cleared. A second awkward case is a status read that lands in the very clock of a new transition. A directed test lines up the read strobe with a modem-control toggle to cover it.

// File: rtl/rts_fc_pkg.sv
// Package: shared types for the automatic RTS flow controller.
// Assumes: nothing beyond IEEE 1800-2017.
package rts_fc_pkg;

    // How the RTS pin is currently decided
    typedef enum logic [1:0] {
        RTS_MANUAL   = 2'd0,  // pin follows the modem-control request
        RTS_HELD_OFF = 2'd1,  // automatic on but not armed: pin de-asserted
        RTS_AUTO     = 2'd2   // automatic and armed: pin follows FIFO level
    } rts_mode_e;

    // Decode the control bits into a mode
    function automatic rts_mode_e decode_mode(input logic auto_en, input logic req);
        if (!auto_en)
            return RTS_MANUAL;
        else if (!req)
            return RTS_HELD_OFF;
        else
            return RTS_AUTO;
    endfunction

endpackage

// File: rtl/rts_level_monitor.sv
// Module: rts_level_monitor
// Tracks whether the remote transmitter should be paused, using two
// thresholds with hysteresis. Pause wins over resume when they overlap.
// Assumes: the memory is cleared whenever automatic mode is not active.
module rts_level_monitor #(
    parameter int LEVEL_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               active,
    input  logic [LEVEL_W-1:0] level,
    input  logic [LEVEL_W-1:0] pause_at,
    input  logic [LEVEL_W-1:0] resume_below,
    output logic               paused_d,
    output logic               paused_q
);

    // Next paused state from the thresholds
    always_comb begin
        paused_d = paused_q;
        if (!active)
            paused_d = 1'b0;
        else if (level >= pause_at)
            paused_d = 1'b1;
        else if (level < resume_below)
            paused_d = 1'b0;
    end

    // Hold the paused state
    always_ff @(posedge clk) begin
        if (!rst_n)
            paused_q <= 1'b0;
        else
            paused_q <= paused_d;
    end

endmodule

// File: rtl/rts_pin_driver.sv
// Module: rts_pin_driver
// Registers the active-low RTS pin from the selected mode and reports
// when the pin is about to change.
// Assumes: reset value of the pin is de-asserted (1).
module rts_pin_driver
    import rts_fc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic auto_en,
    input  logic req,
    input  logic paused_d,
    output logic rts_n_q,
    output logic toggle
);

    rts_mode_e mode;
    logic      rts_n_d;

    // Choose the next pin level
    always_comb begin
        mode = decode_mode(auto_en, req);
        case (mode)
            RTS_MANUAL:   rts_n_d = ~req;
            RTS_HELD_OFF: rts_n_d = 1'b1;
            default:      rts_n_d = paused_d;
        endcase
        toggle = rts_n_d ^ rts_n_q;
    end

    // Register the pin
    always_ff @(posedge clk) begin
        if (!rst_n)
            rts_n_q <= 1'b1;
        else
            rts_n_q <= rts_n_d;
    end

endmodule

// File: rtl/rts_event_irq.sv
// Module: rts_event_irq
// Holds the RTS interrupt enable, which is writable only while unlocked,
// and a sticky status flag set by each enabled pin transition.
// Assumes: a set in the same clock as a read takes priority.
module rts_event_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic unlock,
    input  logic we,
    input  logic wdata,
    input  logic toggle,
    input  logic rd,
    output logic en_q,
    output logic flag_q
);

    // Gated enable register
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= 1'b0;
        else if (we && unlock)
            en_q <= wdata;
    end

    // Sticky status flag, cleared by a read
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (toggle && en_q)
            flag_q <= 1'b1;
        else if (rd)
            flag_q <= 1'b0;
    end

endmodule

// File: rtl/rts_flow_ctrl.sv
// Module: rts_flow_ctrl (top)
// Automatic RTS flow control: pauses the remote transmitter from the
// receive FIFO level once armed, and flags every RTS pin transition.
// Assumes: rx_level is a synchronous count in 0..FIFO_DEPTH.
module rts_flow_ctrl #(
    parameter int FIFO_DEPTH = 32,
    localparam int LEVEL_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LEVEL_W-1:0] rx_level,
    input  logic [LEVEL_W-1:0] pause_level,
    input  logic [LEVEL_W-1:0] resume_level,
    input  logic               auto_rts_en,
    input  logic               feat_unlock,
    input  logic               mcr_rts_a,
    input  logic               mcr_rts_b,
    input  logic               int_en_we,
    input  logic               int_en_wdata,
    input  logic               isr_rd,
    output logic               rts_n,
    output logic               rts_int_en,
    output logic               rts_int_flag,
    output logic               irq
);

    logic req;
    logic paused_d;
    logic paused_q;
    logic toggle;

    // Combined modem-control request
    always_comb req = mcr_rts_a | mcr_rts_b;

    rts_level_monitor #(.LEVEL_W(LEVEL_W)) u_level (
        .clk          (clk),
        .rst_n        (rst_n),
        .active       (auto_rts_en & req),
        .level        (rx_level),
        .pause_at     (pause_level),
        .resume_below (resume_level),
        .paused_d     (paused_d),
        .paused_q     (paused_q)
    );

    rts_pin_driver u_pin (
        .clk      (clk),
        .rst_n    (rst_n),
        .auto_en  (auto_rts_en),
        .req      (req),
        .paused_d (paused_d),
        .rts_n_q  (rts_n),
        .toggle   (toggle)
    );

    rts_event_irq u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .unlock (feat_unlock),
        .we     (int_en_we),
        .wdata  (int_en_wdata),
        .toggle (toggle),
        .rd     (isr_rd),
        .en_q   (rts_int_en),
        .flag_q (rts_int_flag)
    );

    // Request follows the status flag
    always_comb irq = rts_int_flag;

endmodule

// File: rtl/rts_flow_ctrl_chk.sv
// Module: rts_flow_ctrl_chk
// Assertion checker bound to rts_flow_ctrl.
// Assumes: properties are only evaluated after a first clock out of reset.
module rts_flow_ctrl_chk #(
    parameter int LEVEL_W = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic [LEVEL_W-1:0] rx_level,
    input logic [LEVEL_W-1:0] pause_level,
    input logic               auto_rts_en,
    input logic               feat_unlock,
    input logic               mcr_rts_a,
    input logic               mcr_rts_b,
    input logic               isr_rd,
    input logic               rts_n,
    input logic               rts_int_en,
    input logic               rts_int_flag
);

    logic seen;

    // Marks that one clock has passed out of reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            seen <= 1'b0;
        else
            seen <= 1'b1;
    end

    assert_manual_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && !$past(auto_rts_en)) |-> (rts_n == !$past(mcr_rts_a | mcr_rts_b)));

    assert_held_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(auto_rts_en) && !$past(mcr_rts_a | mcr_rts_b)) |-> rts_n);

    assert_pause_at_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(auto_rts_en && (mcr_rts_a | mcr_rts_b) && (rx_level >= pause_level)))
        |-> rts_n);

    assert_locked_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && !$past(feat_unlock)) |-> $stable(rts_int_en));

    assert_flag_on_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(rts_int_en) && (rts_n != $past(rts_n))) |-> rts_int_flag);

    assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(isr_rd) && (rts_n == $past(rts_n))) |-> !rts_int_flag);

endmodule

bind rts_flow_ctrl rts_flow_ctrl_chk #(.LEVEL_W(LEVEL_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_level     (rx_level),
    .pause_level  (pause_level),
    .auto_rts_en  (auto_rts_en),
    .feat_unlock  (feat_unlock),
    .mcr_rts_a    (mcr_rts_a),
    .mcr_rts_b    (mcr_rts_b),
    .isr_rd       (isr_rd),
    .rts_n        (rts_n),
    .rts_int_en   (rts_int_en),
    .rts_int_flag (rts_int_flag)
);

// File: tb/rts_flow_ctrl_test.sv
`timescale 1ns/1ps
module rts_flow_ctrl_test;

    localparam int LW = 6;
    localparam int NV = 15;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [LW-1:0] rx_level = '0;
    logic [LW-1:0] pause_level = 6'd24;
    logic [LW-1:0] resume_level = 6'd8;
    logic          auto_rts_en = 1'b0;
    logic          feat_unlock = 1'b0;
    logic          mcr_rts_a = 1'b0;
    logic          mcr_rts_b = 1'b0;
    logic          int_en_we = 1'b0;
    logic          int_en_wdata = 1'b0;
    logic          isr_rd = 1'b0;
    logic          rts_n;
    logic          rts_int_en;
    logic          rts_int_flag;
    logic          irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rts_flow_ctrl uut (
        .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .pause_level(pause_level),
        .resume_level(resume_level), .auto_rts_en(auto_rts_en), .feat_unlock(feat_unlock),
        .mcr_rts_a(mcr_rts_a), .mcr_rts_b(mcr_rts_b), .int_en_we(int_en_we),
        .int_en_wdata(int_en_wdata), .isr_rd(isr_rd), .rts_n(rts_n),
        .rts_int_en(rts_int_en), .rts_int_flag(rts_int_flag), .irq(irq)
    );

    // {auto, mcr_a, mcr_b, level, pause, resume, expected rts_n}
    localparam logic [21:0] VEC [NV] = '{
        {1'b0, 1'b1, 1'b0, 6'd0,  6'd24, 6'd8,  1'b0},  // R2
        {1'b0, 1'b0, 1'b0, 6'd30, 6'd24, 6'd8,  1'b1},  // R2
        {1'b0, 1'b0, 1'b1, 6'd0,  6'd24, 6'd8,  1'b0},  // R2 via second bit
        {1'b1, 1'b0, 1'b0, 6'd0,  6'd24, 6'd8,  1'b1},  // R3
        {1'b1, 1'b1, 1'b0, 6'd10, 6'd24, 6'd8,  1'b0},  // R4 below pause
        {1'b1, 1'b1, 1'b0, 6'd24, 6'd24, 6'd8,  1'b1},  // R4 at pause
        {1'b1, 1'b1, 1'b0, 6'd15, 6'd24, 6'd8,  1'b1},  // R5 hold in band
        {1'b1, 1'b1, 1'b0, 6'd8,  6'd24, 6'd8,  1'b1},  // R5 at resume
        {1'b1, 1'b1, 1'b0, 6'd7,  6'd24, 6'd8,  1'b0},  // R5 below resume
        {1'b1, 1'b1, 1'b0, 6'd23, 6'd24, 6'd8,  1'b0},  // R5 band from below
        {1'b1, 1'b1, 1'b0, 6'd32, 6'd24, 6'd8,  1'b1},  // R4 full
        {1'b0, 1'b1, 1'b0, 6'd32, 6'd24, 6'd8,  1'b0},  // R10 leave auto
        {1'b1, 1'b1, 1'b0, 6'd15, 6'd24, 6'd8,  1'b0},  // R10 re-arm in band
        {1'b1, 1'b1, 1'b0, 6'd15, 6'd10, 6'd20, 1'b1},  // R6 overlap
        {1'b1, 1'b1, 1'b0, 6'd5,  6'd10, 6'd20, 1'b0}   // R6 below both
    };

    function automatic string vec_tag(input int i);
        case (i)
            0, 1, 2:             return "R2";
            3:                   return "R3";
            4, 5, 10:            return "R4";
            6, 7, 8, 9:          return "R5";
            11, 12:              return "R10";
            default:             return "R6";
        endcase
    endfunction

    task automatic check(input string tag, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    // One clock: drive at falling edge, sample at the next falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_en(input logic unlock, input logic val);
        feat_unlock = unlock;
        int_en_we = 1'b1;
        int_en_wdata = val;
        step();
        int_en_we = 1'b0;
        feat_unlock = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step();
        step();
        // R1 reset values
        check("R1", rts_n, 1'b1, "rts_n in reset");
        check("R1", irq, 1'b0, "irq in reset");
        check("R1", rts_int_flag, 1'b0, "flag in reset");
        check("R1", rts_int_en, 1'b0, "enable in reset");
        rst_n = 1'b1;
        step();

        // Stimulus table, no interrupt enabled
        for (int i = 0; i < NV; i++) begin
            auto_rts_en  = VEC[i][21];
            mcr_rts_a    = VEC[i][20];
            mcr_rts_b    = VEC[i][19];
            rx_level     = VEC[i][18:13];
            pause_level  = VEC[i][12:7];
            resume_level = VEC[i][6:1];
            step();
            check(vec_tag(i), rts_n, VEC[i][0], $sformatf("table step %0d rts_n", i));
        end
        // R8 negative: transitions above happened with enable 0
        check("R8", rts_int_flag, 1'b0, "flag with enable off");

        // Back to manual mode, pin asserted
        auto_rts_en = 1'b0; mcr_rts_a = 1'b1; mcr_rts_b = 1'b0;
        pause_level = 6'd24; resume_level = 6'd8; rx_level = '0;
        step();

        // R7 locked write ignored
        write_en(1'b0, 1'b1);
        check("R7", rts_int_en, 1'b0, "locked write");
        write_en(1'b1, 1'b1);
        check("R7", rts_int_en, 1'b1, "unlocked write");

        // R8 enabled transition sets flag in the same clock as the pin
        mcr_rts_a = 1'b0;
        step();
        check("R8", rts_n, 1'b1, "pin after request drop");
        check("R8", rts_int_flag, 1'b1, "flag on transition");
        check("R8", irq, 1'b1, "irq on transition");
        step();
        check("R9", rts_int_flag, 1'b1, "flag holds without read");

        // R9 read clears
        isr_rd = 1'b1;
        step();
        isr_rd = 1'b0;
        check("R9", rts_int_flag, 1'b0, "flag after read");
        check("R9", irq, 1'b0, "irq after read");

        // R9 read colliding with a new transition
        isr_rd = 1'b1; mcr_rts_a = 1'b1;
        step();
        isr_rd = 1'b0;
        check("R9", rts_n, 1'b0, "pin on collision");
        check("R9", rts_int_flag, 1'b1, "flag kept on collision");

        // R8 auto-mode transition also flags; clear first
        isr_rd = 1'b1;
        step();
        isr_rd = 1'b0;
        auto_rts_en = 1'b1; rx_level = 6'd30;
        step();
        check("R8", rts_n, 1'b1, "auto pause pin");
        check("R8", rts_int_flag, 1'b1, "flag on auto pause");

        // R7 disable while unlocked, then no flag on transition
        isr_rd = 1'b1;
        step();
        isr_rd = 1'b0;
        write_en(1'b1, 1'b0);
        check("R7", rts_int_en, 1'b0, "unlocked clear");
        rx_level = 6'd2;
        step();
        check("R5", rts_n, 1'b0, "resume pin");
        check("R8", rts_int_flag, 1'b0, "no flag when disabled");

        // R1 reset in the middle of operation
        rst_n = 1'b0;
        step();
        check("R1", rts_n, 1'b1, "rts_n after mid reset");
        rst_n = 1'b1;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule